// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 20-bit virtual page number into a physical page number by reading a two-level page table that sits in memory. A root register gives the base of the upper table. Each walk makes at most two word reads through a memory port that has a request channel and a response channel. The upper-table read returns either the base of a lower table or zero, which means the region is unmapped. The lower-table read returns an entry with a frame number, a valid flag, a dirty flag and three access-permission bits.

Only one walk runs at a time. A request is taken on the valid/ready handshake. The walker holds `req_ready` low from the cycle after it accepts a request until its result pulse has ended, so an upstream source simply waits. The memory request channel follows the same rules: `mem_req_valid` and `mem_req_addr` stay constant until `mem_req_ready` is seen high at a clock edge. The response channel has no back-pressure, because the walker is always ready while it waits for a response. The result is a single-cycle `done` pulse, and nothing downstream can stall it.

Top module: `pt_walker`

## Requirements
- R1: `root_we` loads `root_wdata` into the root register. A walk accepted in a later cycle uses the new value. A walk accepted in the same cycle as the write uses the old value.
- R2: `req_ready` is high only while the walker is idle, and a request is taken when `req_valid` and `req_ready` are both high at an edge. `busy` is high from the cycle after acceptance through the `done` cycle. Requests presented while busy have no effect.
- R3: The first read is issued in the cycle after acceptance, at address root + 4 * vpn[19:10].
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address hold unchanged into the next cycle.
- R5: An upper-table word of zero ends the walk with `fault` = 1, and no second read is issued.
- R6: For a non-zero upper-table word P, the second read is issued in the cycle after the first response, at address P + 4 * vpn[9:0].
- R7: A lower-table entry whose bit 0 (valid) is clear ends the walk with `fault` = 1.
- R8: For a lower-table entry whose bit 0 is set, the walk returns `ppn` = entry[31:20] and `perms` = entry[4:2] with `fault` = 0. Bit 1 is the dirty flag and does not affect the result.
- R9: `done` rises in the cycle after the response that ends the walk, lasts exactly one cycle, and is followed by idle.
- R10: A `mem_rsp_valid` pulse that arrives while the walker is not waiting for a response has no effect on the walk or the outputs.
- R11: `fault`, `ppn` and `perms` are zero whenever `done` is low. `ppn` and `perms` are also zero on a faulting result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Load strobe for the root register |
| root_wdata | input | 32 | New root (upper-table base) address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vpn | input | 20 | Virtual page number to translate |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory word read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| done | output | 1 | One-cycle result pulse |
| fault | output | 1 | Result is a page fault |
| ppn | output | 12 | Physical page number of the result |
| perms | output | 3 | Access permissions of the result |

## Verification
The hardest cases to reach from the ports are the ones where timing events overlap. One is a root write in the very cycle a request is accepted. Another is a response pulse that arrives while the walker is still offering a read, or while it is idle. The bench's memory responder is driven by per-walk settings for ready stalls, response latency and stray response pulses. A directed walk asserts the root write and the request on the same edge. A per-cycle behavioural model then checks every output against the expected sequence, so a stray pulse or an early root write that leaks into the walk shows up as a miscompare.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_RD_UP,
    WS_WT_UP,
    WS_RD_LO,
    WS_WT_LO,
    WS_DONE
  } walk_state_e;

endpackage

// File: rtl/pt_root_reg.sv
module pt_root_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] root
);
  always_ff @(posedge clk) begin
    if (!rst_n)  root <= '0;
    else if (we) root <= wdata;
  end
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int W  = 32,
  parameter int IW = 10
) (
  input  logic [W-1:0]  base,
  input  logic [IW-1:0] idx,
  output logic [W-1:0]  addr
);
  localparam int PadW = W - IW - 2;

  // word-sized entries: byte offset is index times four
  assign addr = base + {{PadW{1'b0}}, idx, 2'b00};
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
#(
  parameter int W         = 32,
  parameter int IW        = 10,
  parameter int VALID_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  root,
  input  logic          req_valid,
  input  logic [2*IW-1:0] req_vpn,
  output logic          req_ready,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [W-1:0]  mem_rsp_data,
  output logic [W-1:0]  base_q,
  output logic [IW-1:0] idx,
  output logic          done,
  output logic          fault_q
);
  localparam int VpnW = 2 * IW;

  walk_state_e     state;
  logic [VpnW-1:0] vpn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= WS_IDLE;
      vpn_q   <= '0;
      base_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state)
        WS_IDLE: if (req_valid) begin
          vpn_q   <= req_vpn;
          base_q  <= root;
          fault_q <= 1'b0;
          state   <= WS_RD_UP;
        end
        WS_RD_UP: if (mem_req_ready) state <= WS_WT_UP;
        WS_WT_UP: if (mem_rsp_valid) begin
          base_q <= mem_rsp_data;
          if (mem_rsp_data == '0) begin
            fault_q <= 1'b1;
            state   <= WS_DONE;
          end else begin
            state   <= WS_RD_LO;
          end
        end
        WS_RD_LO: if (mem_req_ready) state <= WS_WT_LO;
        WS_WT_LO: if (mem_rsp_valid) begin
          base_q  <= mem_rsp_data;
          fault_q <= ~mem_rsp_data[VALID_BIT];
          state   <= WS_DONE;
        end
        WS_DONE: begin
          fault_q <= 1'b0;
          state   <= WS_IDLE;
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == WS_IDLE);
  assign busy          = (state != WS_IDLE);
  assign mem_req_valid = (state == WS_RD_UP) || (state == WS_RD_LO);
  assign done          = (state == WS_DONE);
  assign idx           = (state == WS_RD_LO) ? vpn_q[IW-1:0] : vpn_q[VpnW-1:IW];
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int W         = 32,
  parameter int IW        = 10,
  parameter int PPN_W     = 12,
  parameter int PERM_W    = 3,
  parameter int PERM_LSB  = 2,
  parameter int VALID_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              root_we,
  input  logic [W-1:0]      root_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2*IW-1:0]   req_vpn,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [W-1:0]      mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [W-1:0]      mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [PPN_W-1:0]  ppn,
  output logic [PERM_W-1:0] perms
);
  localparam int PpnLsb = W - PPN_W;

  logic [W-1:0]  root;
  logic [W-1:0]  base_q;
  logic [IW-1:0] idx;
  logic          fault_q;
  logic          hit;

  pt_root_reg #(.W(W)) u_root (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (root_we),
    .wdata (root_wdata),
    .root  (root)
  );

  pt_walk_fsm #(.W(W), .IW(IW), .VALID_BIT(VALID_BIT)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .root          (root),
    .req_valid     (req_valid),
    .req_vpn       (req_vpn),
    .req_ready     (req_ready),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .base_q        (base_q),
    .idx           (idx),
    .done          (done),
    .fault_q       (fault_q)
  );

  pt_addr_gen #(.W(W), .IW(IW)) u_addr (
    .base (base_q),
    .idx  (idx),
    .addr (mem_req_addr)
  );

  assign hit   = done && !fault_q;
  assign fault = done && fault_q;
  assign ppn   = hit ? base_q[PpnLsb +: PPN_W]   : '0;
  assign perms = hit ? base_q[PERM_LSB +: PERM_W] : '0;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int W      = 32,
  parameter int PPN_W  = 12,
  parameter int PERM_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [W-1:0]      mem_req_addr,
  input logic              done,
  input logic              fault,
  input logic [PPN_W-1:0]  ppn,
  input logic [PERM_W-1:0] perms
);
  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready);

  // R2
  idle_no_mem_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !done);

  // R4
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R9
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R11
  quiet_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !fault && ppn == '0 && perms == '0);

  // R11
  fault_zero_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ppn == '0 && perms == '0);
endmodule

bind pt_walker pt_walker_chk #(.W(W), .PPN_W(PPN_W), .PERM_W(PERM_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done          (done),
  .fault         (fault),
  .ppn           (ppn),
  .perms         (perms)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_we = 1'b0;
  logic [31:0] root_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vpn = '0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic        fault;
  logic [11:0] ppn;
  logic [2:0]  perms;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault), .ppn(ppn), .perms(perms)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wrap_up;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // ---------------- page table memory and responder ----------------
  bit [31:0] pt_mem [bit [31:0]];
  int  lat = 0;
  bit  stall_en = 0;
  bit  stray_en = 0;
  bit  pend = 0;
  int  pend_cnt = 0;
  logic [31:0] pend_addr = '0;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (pt_mem.exists(a)) return pt_mem[a];
    return 32'h0;
  endfunction

  // ---------------- behavioural reference ----------------
  int          m_phase = 0;
  logic [31:0] m_root = '0, m_base = '0;
  logic [19:0] m_vpn = '0;
  bit          m_fault = 0;
  logic [11:0] m_ppn = '0;
  logic [2:0]  m_perms = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_phase = 0; m_root = '0; m_base = '0; m_fault = 0; m_ppn = '0; m_perms = '0;
    end else begin
      case (m_phase)
        0: if (req_valid) begin
             m_vpn = req_vpn; m_base = m_root; m_phase = 1;
           end
        1: if (mem_req_ready) m_phase = 2;
        2: if (mem_rsp_valid) begin
             if (mem_rsp_data == 0) begin m_fault = 1; m_phase = 5; end
             else begin m_base = mem_rsp_data; m_phase = 3; end
           end
        3: if (mem_req_ready) m_phase = 4;
        4: if (mem_rsp_valid) begin
             if (!mem_rsp_data[0]) m_fault = 1;
             else begin m_ppn = mem_rsp_data[31:20]; m_perms = mem_rsp_data[4:2]; end
             m_phase = 5;
           end
        default: begin m_phase = 0; m_fault = 0; m_ppn = '0; m_perms = '0; end
      endcase
      if (root_we) m_root = root_wdata;
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      wrap_up();
    end
  end

  // per-cycle compare, then memory drive for the coming edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 req_ready", req_ready, m_phase == 0);
      chk("R2 busy", busy, m_phase != 0);
      chk("R4 mem_req_valid", mem_req_valid, m_phase == 1 || m_phase == 3);
      if (m_phase == 1) chk("R3 upper addr", mem_req_addr, m_base + {m_vpn[19:10], 2'b00});
      if (m_phase == 3) chk("R6 lower addr", mem_req_addr, m_base + {m_vpn[9:0], 2'b00});
      chk("R9 done", done, m_phase == 5);
      chk("R5 R7 fault", fault, m_phase == 5 && m_fault);
      chk("R8 R11 ppn", ppn, (m_phase == 5 && !m_fault) ? m_ppn : 12'h0);
      chk("R8 R11 perms", perms, (m_phase == 5 && !m_fault) ? m_perms : 3'h0);
    end
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = $urandom;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_rd(pend_addr);
        pend = 0;
      end else pend_cnt--;
    end else if (stray_en && (cyc % 2 == 0)) begin
      mem_rsp_valid = 1'b1; // R10: stray pulse outside a wait
    end
    mem_req_ready = stall_en ? (cyc % 3 == 0) : 1'b1;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      pend = 1; pend_cnt = lat; pend_addr = mem_req_addr;
    end
  end

  task automatic walk(input logic [19:0] vpn, input logic [31:0] exp_up,
                      input bit exp_fault, input logic [11:0] exp_ppn,
                      input logic [2:0] exp_perms, input bit reload,
                      input logic [31:0] new_root);
    @(negedge clk);
    req_valid = 1'b1; req_vpn = vpn;
    if (reload) begin root_we = 1'b1; root_wdata = new_root; end
    @(negedge clk);
    root_we = 1'b0;
    chk("R1 upper addr from root", mem_req_addr, exp_up);
    req_vpn = ~vpn; // R2: held request while busy is ignored
    while (!done) @(negedge clk);
    chk("R5 R7 walk fault", fault, exp_fault);
    chk("R8 walk ppn", ppn, exp_fault ? 12'h0 : exp_ppn);
    chk("R8 walk perms", perms, exp_fault ? 3'h0 : exp_perms);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_root(input logic [31:0] v);
    @(negedge clk); root_we = 1'b1; root_wdata = v;
    @(negedge clk); root_we = 1'b0;
  endtask

  initial begin
    logic [31:0] r0, r1;
    r0 = 32'h0010_0000;
    r1 = 32'h0040_0000;
    pt_mem[r0 + 4*3]      = 32'h0020_0000;
    pt_mem[r0 + 4*1023]   = 32'h0030_0000;
    pt_mem[32'h0020_0000 + 4*7]    = {12'hABC, 15'h0, 3'b101, 1'b1, 1'b1};
    pt_mem[32'h0020_0000 + 4*8]    = {12'h555, 15'h0, 3'b111, 1'b0, 1'b0};
    pt_mem[32'h0030_0000 + 4*1023] = {12'hFFF, 15'h7FFF, 3'b111, 1'b0, 1'b1};
    pt_mem[r1 + 4*3]      = 32'h0020_0000;

    repeat (3) @(negedge clk);
    chk("R2 reset req_ready", req_ready, 1);
    chk("R11 reset done", done, 0);
    rst_n = 1'b1;

    set_root(r0);
    walk({10'd3, 10'd7}, r0 + 12, 0, 12'hABC, 3'b101, 0, 0);       // R8
    walk({10'd3, 10'd8}, r0 + 12, 1, 0, 0, 0, 0);                  // R7
    walk({10'd5, 10'd1}, r0 + 20, 1, 0, 0, 0, 0);                  // R5
    stall_en = 1; lat = 2; stray_en = 1;                           // R4 R10
    walk({10'd1023, 10'd1023}, r0 + 4092, 0, 12'hFFF, 3'b111, 0, 0);
    walk({10'd3, 10'd7}, r0 + 12, 0, 12'hABC, 3'b101, 0, 0);
    for (int i = 0; i < 16; i++) begin
      logic [9:0] hi, lo;
      logic [31:0] lo_base, pte;
      hi = 10'((i * 37) % 1024) + 10'd40;
      lo = 10'((i * 101) % 1024);
      lo_base = 32'h0100_0000 + 32'(i) * 32'h1000;
      pte = {12'(i * 3 + 1), 15'h1234, 3'(i % 8), 1'(i % 2), 1'(i % 3 != 0)};
      if (i % 2 == 0) begin
        pt_mem[r0 + {hi, 2'b00}] = lo_base;
        pt_mem[lo_base + {lo, 2'b00}] = pte;
      end
      stall_en = (i % 2) == 1; lat = i % 3; stray_en = (i % 4) != 0;
      walk({hi, lo}, r0 + {hi, 2'b00}, (i % 2 == 1) || (i % 3 == 0),
           pte[31:20], pte[4:2], 0, 0);
    end
    stall_en = 0; lat = 0; stray_en = 1;
    // R1: write in the accept cycle uses the old root, next walk the new one
    walk({10'd5, 10'd0}, r0 + 20, 1, 0, 0, 1, r1);
    walk({10'd3, 10'd7}, r1 + 12, 0, 12'hABC, 3'b101, 0, 0);
    // R10: stray pulses while idle leave the outputs quiet
    repeat (6) @(negedge clk);
    chk("R10 idle done", done, 0);
    chk("R10 idle busy", busy, 0);
    wrap_up();
  end
endmodule